// File: doc/BRIEF.md
# Three-State Phase-Frequency Detector with Charge-Pump Control

This block compares two pulse trains, a reference and a divided-down oscillator, and decides which one leads. A rising edge on the reference arms one latch, and a rising edge on the divided signal arms the other. Once both latches are armed, they hold together for a fixed number of system clocks and then clear as a pair. This enforced overlap gives both pump requests a guaranteed minimum width, so the loop has no dead zone around zero phase error. Both inputs are sampled by a fast system clock, and only rising edges count. An edge that arrives while its latch is already armed changes nothing. Because of this, the detector responds to a frequency difference as well as to a phase difference.

The latched requests pass through a polarity stage to become the pump-up and pump-down commands. Setting the invert control swaps the two commands, so the block can drive a loop filter that inverts. A drive-enable output is high whenever either command is active. When it is low, the pump stage is expected to leave its output floating. A current-select output passes on the control-register choice between full and half pump current.

Top module: `pfd_cp_ctrl`

## Requirements
- R1: While reset is held, and after it is released with both inputs low, pump_up, pump_dn and drive_en are all 0.
- R2: With inv_pol=0, a rising edge on ref_in raises pump_up on the next clock edge after it is sampled.
- R3: With inv_pol=0, a rising edge on fb_in raises pump_dn on the next clock edge after it is sampled.
- R4: When the ref_in edge leads the fb_in edge by L sample cycles, the leading command stays high for L+OVL_CYC cycles and the lagging command for OVL_CYC cycles (OVL_CYC defaults to 3). The same holds with the roles swapped when fb_in leads.
- R5: When the two edges are sampled in the same cycle, both commands go high together for exactly OVL_CYC cycles. The two commands are never high together for more than OVL_CYC cycles.
- R6: A second rising edge on the leading input, arriving before the lagging edge, neither restarts nor extends the leading command. It stays one pulse that runs from the first edge until OVL_CYC cycles after the lagging edge.
- R7: With inv_pol=1, every pulse that R2 to R6 place on pump_up appears on pump_dn instead, and the reverse.
- R8: drive_en is 1 exactly when pump_up or pump_dn is 1. Otherwise it is 0, and the pump output is left floating.
- R9: cur_full follows cur_sel: 1 requests full current (1 mA) and 0 requests half current (0.5 mA).
- R10: An input held high produces no further command pulses. Only a low-to-high transition counts as an edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | fast system clock that samples both inputs |
| rst_n | input | 1 | asynchronous reset, active low |
| ref_in | input | 1 | reference pulse train |
| fb_in | input | 1 | divided oscillator pulse train |
| inv_pol | input | 1 | swaps the up and down commands when 1 |
| cur_sel | input | 1 | control-register bit selecting the pump current |
| pump_up | output | 1 | source-current request |
| pump_dn | output | 1 | sink-current request |
| drive_en | output | 1 | pump output driven when 1, floating when 0 |
| cur_full | output | 1 | 1 for full current, 0 for half current |

## Verification
Edge pairs are placed at random offsets: reference leading, divided leading, and both in the same cycle. Measuring the width of each command separates a correct lead-plus-overlap count from an off-by-one in the overlap counter, and from a wrong choice of which latch is armed. Each pattern is repeated under both polarities, which exposes a missing or partial swap. A directed case puts two reference edges before one divided edge, which tells a latch that holds apart from one that retriggers. Holding each input high well after the pair clears shows whether a level is wrongly taken for an edge.

// File: rtl/pfd_pkg.sv
package pfd_pkg;
    // index of each input channel in the edge-detector array
    localparam int unsigned CH_REF = 0;
    localparam int unsigned CH_FB  = 1;
    localparam int unsigned N_CH   = 2;

    typedef struct packed {
        logic up;
        logic dn;
    } pump_pair_t;
endpackage

// File: rtl/pfd_edge_det.sv
module pfd_edge_det (
    input  logic clk,
    input  logic rst_n,
    input  logic sig_in,
    output logic rise_o
);
    typedef struct packed {
        logic prev;
    } edge_st_t;

    edge_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.prev = sig_in;
        rise_o    = sig_in & ~st_q.prev;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // a rise can never be flagged in two consecutive cycles
    assert_single_rise_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> !rise_o);
endmodule

// File: rtl/pfd_latch_core.sv
module pfd_latch_core #(
    parameter int unsigned OVL_CYC = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                rise_ref,
    input  logic                rise_fb,
    output pfd_pkg::pump_pair_t raw_o
);
    localparam int unsigned CNT_W = (OVL_CYC < 2) ? 1 : $clog2(OVL_CYC);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(OVL_CYC - 1);

    typedef struct packed {
        logic             up;
        logic             dn;
        logic [CNT_W-1:0] cnt;
    } core_st_t;

    core_st_t st_d, st_q;
    logic     both_set;
    logic     clr_pair;

    always_comb begin
        st_d     = st_q;
        both_set = st_q.up & st_q.dn;
        clr_pair = both_set & (st_q.cnt == CNT_LAST);
        if (both_set && !clr_pair) st_d.cnt = st_q.cnt + 1'b1;
        else                       st_d.cnt = '0;
        // a new edge wins over the pair clear so it is never lost
        st_d.up = rise_ref | (st_q.up & ~clr_pair);
        st_d.dn = rise_fb  | (st_q.dn & ~clr_pair);
        raw_o.up = st_q.up;
        raw_o.dn = st_q.dn;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assert_overlap_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CNT_LAST);
    assert_ref_arms_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rise_ref |=> st_q.up);
    assert_fb_arms_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rise_fb |=> st_q.dn);
    assert_pair_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.up && st_q.dn && st_q.cnt == CNT_LAST && !rise_ref && !rise_fb)
        |=> (!st_q.up && !st_q.dn));
    assert_lead_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.up && !st_q.dn) |=> st_q.up);
endmodule

// File: rtl/pfd_drive_map.sv
module pfd_drive_map (
    input  pfd_pkg::pump_pair_t raw_i,
    input  logic                inv_pol,
    input  logic                cur_sel,
    output logic                pump_up,
    output logic                pump_dn,
    output logic                drive_en,
    output logic                cur_full
);
    always_comb begin
        pump_up  = inv_pol ? raw_i.dn : raw_i.up;
        pump_dn  = inv_pol ? raw_i.up : raw_i.dn;
        drive_en = raw_i.up | raw_i.dn;
        cur_full = cur_sel;
    end
endmodule

// File: rtl/pfd_cp_ctrl.sv
module pfd_cp_ctrl #(
    parameter int unsigned OVL_CYC = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_in,
    input  logic fb_in,
    input  logic inv_pol,
    input  logic cur_sel,
    output logic pump_up,
    output logic pump_dn,
    output logic drive_en,
    output logic cur_full
);
    import pfd_pkg::*;

    logic [N_CH-1:0] sig_in;
    logic [N_CH-1:0] rise;
    pump_pair_t      raw;

    assign sig_in[CH_REF] = ref_in;
    assign sig_in[CH_FB]  = fb_in;

    for (genvar g = 0; g < N_CH; g++) begin : g_edge
        pfd_edge_det u_edge (
            .clk    (clk),
            .rst_n  (rst_n),
            .sig_in (sig_in[g]),
            .rise_o (rise[g])
        );
    end

    pfd_latch_core #(.OVL_CYC(OVL_CYC)) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .rise_ref (rise[CH_REF]),
        .rise_fb  (rise[CH_FB]),
        .raw_o    (raw)
    );

    pfd_drive_map u_map (
        .raw_i    (raw),
        .inv_pol  (inv_pol),
        .cur_sel  (cur_sel),
        .pump_up  (pump_up),
        .pump_dn  (pump_dn),
        .drive_en (drive_en),
        .cur_full (cur_full)
    );

    assert_float_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!ref_in && !fb_in && !drive_en) |=> !drive_en);
endmodule

// File: tb/tb_pfd_cp_ctrl.sv
module tb_pfd_cp_ctrl;
    localparam int unsigned CLK_PERIOD = 10;
    localparam int unsigned OVL = 3;

    logic clk = 0, rst_n = 0;
    logic ref_in = 0, fb_in = 0, inv_pol = 0, cur_sel = 0;
    logic pump_up, pump_dn, drive_en, cur_full;
    int n_chk = 0, n_fail = 0;

    pfd_cp_ctrl #(.OVL_CYC(OVL)) dut (
        .clk(clk), .rst_n(rst_n), .ref_in(ref_in), .fb_in(fb_in),
        .inv_pol(inv_pol), .cur_sel(cur_sel), .pump_up(pump_up),
        .pump_dn(pump_dn), .drive_en(drive_en), .cur_full(cur_full));

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int lead_width(int first, int second);
        return second - first + OVL;
    endfunction

    // run one edge pair; ref rises at cycle tr, fb at td; optional second
    // ref edge (ref low at cycle rlo, high again at rhi) when rlo >= 0
    task automatic trial(int tr, int td, bit inv, bit cs, int rlo, int rhi,
                         string tag);
        int up_w = 0, dn_w = 0, both_w = 0, en_bad = 0, tail = 0;
        int last = (tr > td ? tr : td) + OVL + 4;
        int exp_r, exp_f, exp_up, exp_dn;
        inv_pol = inv; cur_sel = cs;
        repeat (3) @(negedge clk);
        for (int t = 0; t < last + 12; t++) begin
            @(negedge clk);
            if (pump_up) up_w++;
            if (pump_dn) dn_w++;
            if (pump_up && pump_dn) both_w++;
            if (drive_en != (pump_up | pump_dn)) en_bad++;
            if (t > last && (pump_up || pump_dn)) tail++;
            ref_in = (t >= tr) && !(rlo >= 0 && t >= rlo && t < rhi);
            fb_in  = (t >= td);
        end
        if (tr == td) begin exp_r = OVL; exp_f = OVL; end
        else if (tr < td) begin exp_r = lead_width(tr, td); exp_f = OVL; end
        else begin exp_r = OVL; exp_f = lead_width(td, tr); end
        exp_up = inv ? exp_f : exp_r;
        exp_dn = inv ? exp_r : exp_f;
        check({tag, " up width R4 R7"}, up_w, exp_up);
        check({tag, " dn width R4 R7"}, dn_w, exp_dn);
        check({tag, " overlap R5"}, both_w, OVL);
        check({tag, " drive_en R8"}, en_bad, 0);
        check({tag, " held level R10"}, tail, 0);
        check({tag, " cur_full R9"}, int'(cur_full), int'(cs));
        ref_in = 0; fb_in = 0;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        void'($urandom(32'h5eed_0042));
        repeat (3) @(negedge clk);
        check("reset R1", int'({pump_up, pump_dn, drive_en}), 0);
        rst_n = 1;
        repeat (2) @(negedge clk);
        check("after reset R1", int'({pump_up, pump_dn, drive_en}), 0);
        // directed R2/R3 latency: edge driven at a negedge shows after one posedge
        ref_in = 1; @(negedge clk);
        check("ref arms up R2", int'(pump_up), 1);
        fb_in = 1;  @(negedge clk);
        check("fb arms dn R3", int'(pump_dn), 1);
        repeat (OVL + 2) @(negedge clk);
        ref_in = 0; fb_in = 0; repeat (3) @(negedge clk);
        trial(0, 0, 0, 1, -1, 0, "simultaneous R5");
        trial(0, 0, 1, 0, -1, 0, "simultaneous inv R7");
        trial(0, 7, 0, 1, -1, 0, "ref leads R4");
        trial(9, 2, 1, 0, -1, 0, "fb leads inv R7");
        trial(0, 20, 0, 0, 4, 10, "double ref R6");
        trial(0, 20, 1, 1, 4, 10, "double ref inv R6");
        for (int k = 0; k < 40; k++) begin
            int a = $urandom_range(0, 25);
            int b = $urandom_range(0, 25);
            trial(a, b, 1'($urandom), 1'($urandom), -1, 0, "random R4");
        end
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog R1 actual=timeout expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule